// File: doc/BRIEF.md
# Timer Slave-Mode and Clock-Source Controller

This block sits beside a general-purpose up-counter and its prescaler. It decides what advances the prescaler and when the counter runs, restarts or issues an update. By default the prescaler advances on every bus clock. When the slave field selects external clocking, it advances once per rising edge of a chosen trigger input, so the counter counts events. The other slave settings tie the counter to the chosen trigger in one of three ways. A restart setting reinitialises the counter on each trigger edge. A pause setting gates the counter with the trigger level. A resume setting starts a halted counter again on a trigger edge.

The trigger is picked by a select field. Code 0 picks the software update-generate bit. Codes 1 to NUM_EXT pick external level inputs, which pass through a two-stage synchroniser before their rising edges are detected. Code NUM_EXT+1 picks the channel both-edge pulse, which is already a single-cycle internal strobe and has no level. The counter core, the reload register and software access sit outside the block. Only their control strobes cross its edge.

Top module: `tsm_top`

## Requirements
- R1: While rstN is low and after it rises, trigFlag is 0, and every synchroniser and the resume latch start cleared.
- R2: For modeSel values 0 to 6, pscTick is 1 on every cycle.
- R3: With modeSel = 7 and trigSel naming an external input k (trigSel = k+1), a rising edge on trigIn[k] gives one pscTick pulse of exactly one cycle. The pulse is high in the second cycle after the edge that first samples the new level. Otherwise pscTick is 0. With trigSel = NUM_EXT+1, each chanEdge pulse gives pscTick in the same cycle.
- R4: With modeSel = 7 and trigSel = 0, pscTick stays 0. A swUpdGen pulse, in any mode, raises cntReset and also raises updEvt unless updDisable is 1.
- R5: With modeSel = 4, a selected trigger rising edge raises cntReset in its cycle and sets trigFlag from the next cycle.
- R6: With modeSel = 4 and updDisable = 1, a trigger edge still raises cntReset but updEvt stays 0. With updDisable = 0, updEvt goes high together with cntReset.
- R7: With modeSel = 5, cntEn equals swRun AND the synchronised selected level. The trigger never raises cntReset in this mode.
- R8: With modeSel = 6, cntEn follows an internal run latch. A trigger edge sets the latch, so counting resumes in the next cycle. A falling swRun clears it, and a rising swRun sets it. No trigger activity ever clears it.
- R9: With modeSel = 6 and trigSel = 0, a swUpdGen pulse never sets the run latch, so cntEn stays 0 while swRun stays 0.
- R10: With modeSel = 5 and trigSel = NUM_EXT+1 (the channel both-edge pulse), cntEn stays 0, because that source has no level.
- R11: trigFlag is set by any selected trigger edge while modeSel is 4 to 7, and only then. It stays set until a flagClr pulse. When a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 3 | Slave setting: 4 restart, 5 pause, 6 resume, 7 external clock, others free-running |
| trigSel | input | SEL_W | Trigger select: 0 software, 1..NUM_EXT external input, NUM_EXT+1 channel both-edge pulse |
| trigIn | input | NUM_EXT | Asynchronous external trigger levels |
| chanEdge | input | 1 | Single-cycle channel both-edge strobe |
| swUpdGen | input | 1 | Software update-generate pulse |
| updDisable | input | 1 | Suppresses update events |
| swRun | input | 1 | Software counter-enable level |
| flagClr | input | 1 | Write-one-to-clear pulse for trigFlag |
| pscTick | output | 1 | Prescaler clock enable |
| cntEn | output | 1 | Counter enable |
| cntReset | output | 1 | Reinitialise counter and prescaler |
| updEvt | output | 1 | Update event (preload transfer) |
| trigFlag | output | 1 | Sticky trigger event flag |

## Verification
The assertions check several local rules on every cycle. A synchronised edge lasts one cycle. The flag stays set until cleared, and a restart edge sets it. Pause mode never resets the counter. A running resume latch is never stopped by the trigger, and a software source never restarts a halted one. A pause source without a level keeps the counter idle. Only the bench's scenarios can show the two-cycle synchroniser latency and the exact pulse count in event-counting mode. The same holds for the interaction of updDisable with restart edges and the stop-then-resume order in resume mode, and these are compared against a behavioural model on every clock.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
  localparam logic [2:0] SM_RESTART = 3'd4;
  localparam logic [2:0] SM_PAUSE   = 3'd5;
  localparam logic [2:0] SM_RESUME  = 3'd6;
  localparam logic [2:0] SM_EXTCLK  = 3'd7;

  // strobes handed from the trigger datapath to the mode control
  typedef struct packed {
    logic level;   // synchronised level of the selected source
    logic rise;    // one-cycle rising-edge strobe of the selected source
    logic isSoft;  // software update bit is the selected source
  } trig_t;
endpackage

// File: rtl/tsm_trigpath.sv
module tsm_trigpath
  import tsm_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] trigIn,
  input  logic               chanEdge,
  input  logic [SEL_W-1:0]   trigSel,
  output trig_t              trig
);
  localparam logic [SEL_W-1:0] CHAN_SEL = SEL_W'(NUM_EXT + 1);

  logic [NUM_EXT-1:0] syncLvl;
  logic [NUM_EXT-1:0] syncRise;

  for (genvar i = 0; i < NUM_EXT; i++) begin : g_src
    // SYNC_STAGES flops of synchroniser plus one history flop for edge detect
    logic [SYNC_STAGES:0] chain;
    always_ff @(posedge clk) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-1:0], trigIn[i]};
    end
    assign syncLvl[i]  = chain[SYNC_STAGES-1];
    assign syncRise[i] = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    a_r3_rise_single: assert property (@(posedge clk) disable iff (!rstN)
      syncRise[i] |=> !syncRise[i]);
  end

  always_comb begin
    trig        = '0;
    trig.isSoft = (trigSel == '0);
    for (int i = 0; i < NUM_EXT; i++) begin
      if (trigSel == SEL_W'(i + 1)) begin
        trig.level = syncLvl[i];
        trig.rise  = syncRise[i];
      end
    end
    if (trigSel == CHAN_SEL) begin
      trig.level = 1'b0;      // both-edge strobe carries no level
      trig.rise  = chanEdge;
    end
  end
endmodule

// File: rtl/tsm_modectl.sv
module tsm_modectl
  import tsm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] modeSel,
  input  trig_t      trig,
  input  logic       swUpdGen,
  input  logic       updDisable,
  input  logic       swRun,
  input  logic       flagClr,
  output logic       pscTick,
  output logic       cntEn,
  output logic       cntReset,
  output logic       updEvt,
  output logic       trigFlag
);
  logic slaveOn;
  logic runLatch;
  logic prevSwRun;
  logic restartHit;

  assign slaveOn    = modeSel[2];
  assign restartHit = (modeSel == SM_RESTART) && trig.rise;

  always_comb begin
    if (modeSel == SM_EXTCLK) pscTick = trig.rise && !trig.isSoft;
    else                      pscTick = 1'b1;
  end

  always_comb begin
    unique case (modeSel)
      SM_PAUSE:  cntEn = swRun && trig.level;
      SM_RESUME: cntEn = runLatch;
      default:   cntEn = swRun;
    endcase
  end

  assign cntReset = restartHit || swUpdGen;
  assign updEvt   = cntReset && !updDisable;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runLatch  <= 1'b0;
      prevSwRun <= 1'b0;
    end else begin
      prevSwRun <= swRun;
      if (modeSel == SM_RESUME) begin
        if (trig.rise)                runLatch <= 1'b1;
        else if (prevSwRun && !swRun) runLatch <= 1'b0;
        else if (!prevSwRun && swRun) runLatch <= 1'b1;
      end else begin
        runLatch <= swRun;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      trigFlag <= 1'b0;
    else if (slaveOn && trig.rise)  trigFlag <= 1'b1;
    else if (flagClr)               trigFlag <= 1'b0;
  end

  a_r5_restart_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SM_RESTART && trig.rise) |=> trigFlag);
  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (trigFlag && !flagClr) |=> trigFlag);
  a_r7_pause_no_reset: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SM_PAUSE && !swUpdGen) |-> !cntReset);
  a_r8_trigger_never_stops: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SM_RESUME && runLatch && swRun) |=> runLatch);
  a_r9_soft_no_resume: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SM_RESUME && trig.isSoft && !runLatch && !swRun) |=> !runLatch);
endmodule

// File: rtl/tsm_top.sv
module tsm_top
  import tsm_pkg::*;
#(
  parameter int NUM_EXT     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W       = $clog2(NUM_EXT + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         modeSel,
  input  logic [SEL_W-1:0]   trigSel,
  input  logic [NUM_EXT-1:0] trigIn,
  input  logic               chanEdge,
  input  logic               swUpdGen,
  input  logic               updDisable,
  input  logic               swRun,
  input  logic               flagClr,
  output logic               pscTick,
  output logic               cntEn,
  output logic               cntReset,
  output logic               updEvt,
  output logic               trigFlag
);
  trig_t trig;

  tsm_trigpath #(.NUM_EXT(NUM_EXT), .SEL_W(SEL_W), .SYNC_STAGES(SYNC_STAGES)) u_path (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .chanEdge(chanEdge),
    .trigSel(trigSel), .trig(trig)
  );

  tsm_modectl u_ctl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .trig(trig),
    .swUpdGen(swUpdGen), .updDisable(updDisable), .swRun(swRun), .flagClr(flagClr),
    .pscTick(pscTick), .cntEn(cntEn), .cntReset(cntReset), .updEvt(updEvt),
    .trigFlag(trigFlag)
  );

  a_r10_pause_needs_level: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == SM_PAUSE && trigSel == SEL_W'(NUM_EXT + 1)) |-> !cntEn);
endmodule

// File: tb/tb_tsm_top.sv
`timescale 1ns/1ps
module tb_tsm_top;
  localparam int NUM_EXT = 3;
  localparam int SEL_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] modeSel = 3'd0;
  logic [SEL_W-1:0] trigSel = '0;
  logic [NUM_EXT-1:0] trigIn = '0;
  logic chanEdge = 1'b0, swUpdGen = 1'b0, updDisable = 1'b0, swRun = 1'b0, flagClr = 1'b0;
  logic pscTick, cntEn, cntReset, updEvt, trigFlag;

  int compared = 0;
  int mismatched = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [NUM_EXT-1:0] smp[$];
  bit flagM = 0, runM = 0, prevRun = 0;

  always #10 clk = ~clk;

  tsm_top #(.NUM_EXT(NUM_EXT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .trigSel(trigSel), .trigIn(trigIn),
    .chanEdge(chanEdge), .swUpdGen(swUpdGen), .updDisable(updDisable), .swRun(swRun),
    .flagClr(flagClr), .pscTick(pscTick), .cntEn(cntEn), .cntReset(cntReset),
    .updEvt(updEvt), .trigFlag(trigFlag)
  );

  function automatic bit extSel();
    return (trigSel >= 1) && (trigSel <= NUM_EXT);
  endfunction

  // level seen two samples back, edge between samples two and three back
  function automatic bit mLevel();
    if (!extSel()) return 0;
    return smp[1][trigSel-1];
  endfunction

  function automatic bit mRise();
    if (extSel()) return smp[1][trigSel-1] && !smp[2][trigSel-1];
    if (trigSel == NUM_EXT + 1) return chanEdge;
    return 0;
  endfunction

  initial begin
    smp = '{default: '0};
    repeat (3) smp.push_back('0);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      smp = {};
      repeat (3) smp.push_back('0);
      flagM = 0; runM = 0; prevRun = 0;
    end else begin
      bit rs;
      rs = mRise();
      if (modeSel >= 4 && rs) flagM = 1;
      else if (flagClr) flagM = 0;
      if (modeSel == 6) begin
        if (rs) runM = 1;
        else if (prevRun && !swRun) runM = 0;
        else if (!prevRun && swRun) runM = 1;
      end else runM = swRun;
      prevRun = swRun;
      smp.push_front(trigIn);
      void'(smp.pop_back());
    end
  end

  task automatic check(string nm, logic act, bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at %0t: actual %b expected %b", curReq, nm, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #2;
    begin
      bit rs, eTick, eEn, eRst;
      rs = mRise();
      eTick = (modeSel == 7) ? (trigSel != 0 && rs) : 1'b1;
      eEn = (modeSel == 5) ? (swRun && mLevel()) : (modeSel == 6) ? runM : swRun;
      eRst = (modeSel == 4 && rs) || swUpdGen;
      check("pscTick", pscTick, eTick);
      check("cntEn", cntEn, eEn);
      check("cntReset", cntReset, eRst);
      check("updEvt", updEvt, eRst && !updDisable);
      check("trigFlag", trigFlag, flagM);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseIn(int k, int hi, int lo);
    trigIn[k] = 1'b1; idle(hi);
    trigIn[k] = 1'b0; idle(lo);
  endtask

  task automatic pulseSw();
    swUpdGen = 1'b1; idle(1); swUpdGen = 1'b0; idle(2);
  endtask

  task automatic pulseChan();
    chanEdge = 1'b1; idle(1); chanEdge = 1'b0; idle(2);
  endtask

  task automatic clearFlag();
    flagClr = 1'b1; idle(1); flagClr = 1'b0; idle(1);
  endtask

  initial begin
    // R1: reset state while held and just after release
    curReq = "R1"; trigIn = '1; idle(4);
    trigIn = '0; idle(2);
    rstN = 1'b1; idle(4);

    // R2: bus-clocked prescaler in every non-external setting
    curReq = "R2"; swRun = 1'b1; trigSel = 3'd1;
    for (int m = 0; m < 7; m++) begin
      modeSel = 3'(m); idle(2);
    end
    modeSel = 3'd0; pulseIn(0, 3, 3); clearFlag();

    // R3: event counting from an external source and the channel strobe
    curReq = "R3"; modeSel = 3'd7; trigSel = 3'd2; idle(3);
    pulseIn(1, 1, 4); pulseIn(1, 5, 2); pulseIn(1, 2, 1);
    pulseIn(0, 3, 3); // unselected input gives no tick
    trigSel = 3'd4; pulseChan(); pulseChan();
    clearFlag();

    // R4: software source with external clocking
    curReq = "R4"; trigSel = 3'd0; updDisable = 1'b0; pulseIn(1, 3, 3); pulseSw();
    updDisable = 1'b1; pulseSw(); updDisable = 1'b0;
    modeSel = 3'd1; pulseSw();

    // R5/R6: restart on trigger with update enabled and disabled
    curReq = "R5"; modeSel = 3'd4; trigSel = 3'd1; idle(3);
    pulseIn(0, 2, 4);
    curReq = "R11"; idle(3); clearFlag();
    curReq = "R6"; updDisable = 1'b1; pulseIn(0, 2, 4);
    updDisable = 1'b0; pulseIn(0, 1, 4);
    clearFlag();

    // R7: pause gating by synchronised level
    curReq = "R7"; modeSel = 3'd5; trigSel = 3'd3; swRun = 1'b1; idle(2);
    pulseIn(2, 5, 4); pulseIn(2, 1, 3);
    swRun = 1'b0; pulseIn(2, 4, 3); swRun = 1'b1;
    clearFlag();

    // R8: resume mode stop and restart
    curReq = "R8"; modeSel = 3'd6; trigSel = 3'd1; swRun = 1'b1; idle(3);
    pulseIn(0, 2, 3);       // trigger while running: still running
    swRun = 1'b0; idle(3);  // software stop
    pulseIn(0, 2, 4);       // edge resumes
    pulseIn(0, 1, 3);
    swRun = 1'b1; idle(2); swRun = 1'b0; idle(3);
    clearFlag();

    // R9: software source cannot resume
    curReq = "R9"; trigSel = 3'd0; idle(2);
    pulseSw(); pulseSw(); pulseIn(0, 2, 3);

    // R10: pause with the level-less channel strobe
    curReq = "R10"; modeSel = 3'd5; trigSel = 3'd4; swRun = 1'b1;
    pulseChan(); idle(2); pulseChan();
    clearFlag();

    // R11: set only in slave settings, set wins over clear
    curReq = "R11"; modeSel = 3'd2; trigSel = 3'd1; pulseIn(0, 2, 4);
    modeSel = 3'd5; trigSel = 3'd4;
    chanEdge = 1'b1; flagClr = 1'b1; idle(1);
    chanEdge = 1'b0; flagClr = 1'b0; idle(3);
    clearFlag(); idle(2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule